// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block is the digital back end of a clock synthesizer. It takes the synthesized oscillator clock and a reference clock. A 2-bit source code decides whether the divider runs from the synthesized clock or from the reference clock, with the loop bypassed. The chosen clock is divided by one of eight ratios picked by a 3-bit code. Every ratio, odd ones included, gives an output that is high for exactly half of its period. A half-cycle retimed copy of the count supplies the odd ratios, and the ÷1 setting passes the clock straight through.

The divided clock drives a complementary output pair. The reference clock is passed to a single-ended reference output. An active-high master reset forces the true output low and the complement high. Its release is retimed to the selected clock, so the first output period is complete. A 2-bit code stands in for a three-level enable pin and is decoded into one enable flag for each output. A new ratio takes effect only when the divider wraps, so a ratio change never produces a short pulse.

Top module: `clkout_div`

## Requirements
- R1: The ratio code `div_sel` selects 000→÷1, 001→÷2, 010→÷3, 011→÷4, 100→÷5, 101→÷6, 110→÷8 and 111→÷10. The output period equals the ratio times the selected clock period.
- R2: For every ratio, including 3 and 5, the true output `q` is high for exactly half of the output period and low for the other half.
- R3: At ratio ÷1, `q` follows the selected clock, with the same high time and the same low time.
- R4: While `mr` is 1, `q` is 0 and `qn` is 1. At all times `qn` is the inverse of `q`.
- R5: After `mr` falls, `q` stays 0 until the second rising edge of the selected clock. The first output period after release is a full period.
- R6: The internal count runs from 0 up to the ratio minus one, steps by one on each rising edge of the selected clock, and then wraps to 0.
- R7: A change of `div_sel` takes effect only at the divider wrap. The output period in progress finishes at the old ratio, and the following periods use the new ratio.
- R8: `src_sel` = 11 clocks the divider from `ref_clk` (bypass). The codes 00, 01 and 10 all clock it from `vco_clk`.
- R9: `oe_code` encoding: 00 (pin low) sets `q_en`=0 and `ref_en`=0. 01 (pin high) sets `q_en`=0 and `ref_en`=1. 10 (pin floating) sets `q_en`=1 and `ref_en`=0. 11 is reserved and clears both flags. The two flags are never set together.
- R10: `ref_out` carries `ref_clk` at all times, whatever the state of `mr` and the source code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Synthesized oscillator clock |
| ref_clk | input | 1 | Reference clock, used as the bypass source and for the reference output |
| mr | input | 1 | Master reset, active high, asynchronous to the selected clock |
| src_sel | input | 2 | Source code; 11 selects the bypass |
| div_sel | input | 3 | Ratio code |
| oe_code | input | 2 | Encoded three-level output enable |
| q | output | 1 | True output of the divided clock |
| qn | output | 1 | Complement output of the divided clock |
| q_en | output | 1 | Drive enable for the complementary pair |
| ref_out | output | 1 | Reference clock output |
| ref_en | output | 1 | Drive enable for the reference output |

## Verification
The hardest case to reach is a ratio change while the divider is running. The bench has to make the change early in an output period, so that the old ratio still owns that period, and it has to predict which period first shows the new ratio. The scoreboard holds one item per expected output period. The driver waits until the monitor has consumed all but one of the items for the old ratio, which happens exactly at a rising output edge. It changes the code one nanosecond later and queues the periods at the new ratio. This is done for an even-to-even change and for an odd-to-odd change. Odd ratios are timed at half-cycle resolution, so an odd period that is half a clock too long is also detected.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int MAX_RATIO = 10;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int SYNC_LEN  = 2;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [2:0]         div_code_t;

    typedef enum logic [1:0] {
        SRC_OSC0 = 2'b00,
        SRC_OSC1 = 2'b01,
        SRC_EXT  = 2'b10,
        SRC_BYP  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        OE_LOW  = 2'b00,
        OE_HIGH = 2'b01,
        OE_MID  = 2'b10,
        OE_RSVD = 2'b11
    } oe_e;

    typedef struct packed {
        logic pair_en;
        logic ref_en;
    } oe_flags_t;

    function automatic ratio_t ratio_of(input div_code_t c);
        case (c)
            3'd0:    return ratio_t'(1);
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(3);
            3'd3:    return ratio_t'(4);
            3'd4:    return ratio_t'(5);
            3'd5:    return ratio_t'(6);
            3'd6:    return ratio_t'(8);
            default: return ratio_t'(10);
        endcase
    endfunction

    // Number of rising-edge cycles the count stays in its high phase.
    function automatic ratio_t high_len(input ratio_t r);
        logic [RATIO_W:0] t;
        t = {1'b0, r} + {{RATIO_W{1'b0}}, 1'b1};
        return t[RATIO_W:1];
    endfunction

    function automatic oe_flags_t oe_decode(input oe_e c);
        oe_flags_t f;
        f = '0;
        case (c)
            OE_HIGH: f.ref_en  = 1'b1;
            OE_MID:  f.pair_en = 1'b1;
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cdiv_src_sel.sv
module cdiv_src_sel
    import cdiv_pkg::*;
(
    input  logic       vco_clk,
    input  logic       ref_clk,
    input  logic [1:0] src_sel,
    output logic       sel_clk
);
    // Codes 00, 01 and 10 differ only upstream; all use the synthesized clock.
    assign sel_clk = (src_e'(src_sel) == SRC_BYP) ? ref_clk : vco_clk;
endmodule

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mr,
    output logic hold
);
    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) shift_q <= mr;
        end else begin : g_chain
            always_ff @(posedge clk) shift_q <= {shift_q[STAGES-2:0], mr};
        end
    endgenerate

    // Assertion of reset is immediate; release waits for the chain.
    assign hold = mr | shift_q[STAGES-1];
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic      clk,
    input  logic      hold,
    input  div_code_t div_sel,
    output logic      div_out
);
    ratio_t cnt_q;
    ratio_t ratio_q;
    logic   wrap;
    logic   pos_ph;
    logic   neg_q;

    assign wrap   = (cnt_q == ratio_t'(ratio_q - ratio_t'(1)));
    assign pos_ph = (cnt_q < high_len(ratio_q));

    // A new ratio is sampled only at the wrap or during reset.
    always_ff @(posedge clk) begin
        if (hold || wrap) begin
            cnt_q   <= '0;
            ratio_q <= ratio_of(div_sel);
        end else begin
            cnt_q <= cnt_q + ratio_t'(1);
        end
    end

    // Half-cycle retimed copy of the high phase, used for odd ratios.
    always_ff @(negedge clk) begin
        neg_q <= hold ? 1'b0 : pos_ph;
    end

    always_comb begin
        if (ratio_q == ratio_t'(1))
            div_out = clk;
        else if (ratio_q[0])
            div_out = pos_ph & neg_q;
        else
            div_out = pos_ph;
    end

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (hold)
        cnt_q < ratio_q);

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (hold)
        !wrap |=> cnt_q == ratio_t'($past(cnt_q) + ratio_t'(1)));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (hold)
        wrap |=> cnt_q == '0);

    assert_ratio_at_wrap_R7: assert property (@(posedge clk) disable iff (hold)
        !$stable(ratio_q) |-> $past(wrap));
endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import cdiv_pkg::*;
(
    input  logic       vco_clk,
    input  logic       ref_clk,
    input  logic       mr,
    input  logic [1:0] src_sel,
    input  logic [2:0] div_sel,
    input  logic [1:0] oe_code,
    output logic       q,
    output logic       qn,
    output logic       q_en,
    output logic       ref_out,
    output logic       ref_en
);
    logic      sel_clk;
    logic      hold;
    logic      div_out;
    oe_flags_t flags;

    cdiv_src_sel u_src (
        .vco_clk (vco_clk),
        .ref_clk (ref_clk),
        .src_sel (src_sel),
        .sel_clk (sel_clk)
    );

    cdiv_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (sel_clk),
        .mr   (mr),
        .hold (hold)
    );

    cdiv_core u_core (
        .clk     (sel_clk),
        .hold    (hold),
        .div_sel (div_sel),
        .div_out (div_out)
    );

    assign q       = div_out & ~hold;
    assign qn      = ~q;
    assign ref_out = ref_clk;
    assign flags   = oe_decode(oe_e'(oe_code));
    assign q_en    = flags.pair_en;
    assign ref_en  = flags.ref_en;

    always_comb begin
        assert_oe_excl_R9: assert ($onehot0({q_en, ref_en}));
        if (mr === 1'b1) begin
            assert_reset_pol_R4: assert (q == 1'b0 && qn == 1'b1);
        end
    end
endmodule

// File: tb/clkout_div_tb.sv
`timescale 1ns/1ps
module clkout_div_tb;

    localparam int VCO_HALF = 5;
    localparam int REF_HALF = 8;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       mr      = 1'b1;
    logic [1:0] src_sel = 2'b00;
    logic [2:0] div_sel = 3'b011;
    logic [1:0] oe_code = 2'b00;
    logic q, qn, q_en, ref_out, ref_en;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        longint hi;
        longint lo;
        string  tag;
    } exp_t;
    exp_t sb[$];

    logic   have_rise = 1'b0;
    logic   have_fall = 1'b0;
    longint t_rise = 0;
    longint t_fall = 0;

    always #VCO_HALF vco_clk = ~vco_clk;
    always #REF_HALF ref_clk = ~ref_clk;

    clkout_div u_dut (
        .vco_clk (vco_clk),
        .ref_clk (ref_clk),
        .mr      (mr),
        .src_sel (src_sel),
        .div_sel (div_sel),
        .oe_code (oe_code),
        .q       (q),
        .qn      (qn),
        .q_en    (q_en),
        .ref_out (ref_out),
        .ref_en  (ref_en)
    );

    function automatic int spec_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 5;
            3'd5: return 6;
            3'd6: return 8;
            default: return 10;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every completed output period is compared against the queue.
    always @(posedge q) begin
        if (have_rise && have_fall && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check((t_fall - t_rise) == e.hi, {e.tag, " high"}, t_fall - t_rise, e.hi);
            check(($time - t_fall) == e.lo, {e.tag, " low"}, $time - t_fall, e.lo);
        end
        t_rise    = $time;
        have_rise = 1'b1;
        have_fall = 1'b0;
    end

    always @(negedge q) begin
        if (have_rise) begin
            t_fall    = $time;
            have_fall = 1'b1;
        end
    end

    task automatic push_periods(input logic [1:0] src, input logic [2:0] code,
                                input int n, input string tag);
        int half;
        half = (src == 2'b11) ? REF_HALF : VCO_HALF;
        for (int i = 0; i < n; i++)
            sb.push_back('{hi: longint'(spec_ratio(code) * half),
                           lo: longint'(spec_ratio(code) * half), tag: tag});
    endtask

    task automatic hold_and_setup(input logic [1:0] src, input logic [2:0] code);
        mr      = 1'b1;
        src_sel = src;
        div_sel = code;
        #80;
        have_rise = 1'b0;
        check(q == 1'b0 && qn == 1'b1, "R4 reset polarity", {q, qn}, 2'b01);
    endtask

    task automatic run_case(input logic [1:0] src, input logic [2:0] code,
                            input int n, input string tag);
        hold_and_setup(src, code);
        push_periods(src, code, n, tag);
        #3 mr = 1'b0;
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic change_case(input logic [2:0] c_old, input logic [2:0] c_new, input string tag);
        hold_and_setup(2'b00, c_old);
        push_periods(2'b00, c_old, 3, tag);
        #3 mr = 1'b0;
        wait (sb.size() == 1);
        #1 div_sel = c_new;
        push_periods(2'b00, c_new, 3, tag);
        wait (sb.size() == 0);
        #1;
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        // R9: enable decode, 00 low, 01 high, 10 floating, 11 reserved
        for (int c = 0; c < 4; c++) begin
            logic [1:0] exp_f;
            oe_code = 2'(c);
            #1;
            exp_f = (c == 1) ? 2'b01 : (c == 2) ? 2'b10 : 2'b00;
            check({q_en, ref_en} == exp_f, "R9 enable flags", {q_en, ref_en}, exp_f);
        end
        oe_code = 2'b10;

        // R4: reset state
        #20;
        check(q == 1'b0 && qn == 1'b1, "R4 reset state", {q, qn}, 2'b01);

        // R10: the reference output follows ref_clk, here while in reset
        @(posedge ref_clk); #2;
        check(ref_out == 1'b1, "R10 ref_out high phase", ref_out, 1);
        @(negedge ref_clk); #2;
        check(ref_out == 1'b0, "R10 ref_out low phase", ref_out, 0);

        // R1 R2 R3 R6: every ratio on the synthesized clock
        for (int k = 0; k < 8; k++)
            run_case(2'b00, 3'(k), 2, $sformatf("R1/R2 ratio code %0d", k));

        // R8: other source codes
        run_case(2'b01, 3'b010, 2, "R8 src01 div3");
        run_case(2'b10, 3'b101, 2, "R8 src10 div6");
        run_case(2'b11, 3'b000, 3, "R8 R3 bypass div1");
        run_case(2'b11, 3'b100, 2, "R8 bypass div5");
        run_case(2'b11, 3'b111, 2, "R8 bypass div10");

        // R10 while running in bypass
        mr = 1'b0;
        @(posedge ref_clk); #3;
        check(ref_out == 1'b1, "R10 ref_out running", ref_out, 1);

        // R5: release waits for the second selected-clock edge
        hold_and_setup(2'b00, 3'b011);
        @(posedge vco_clk); #2 mr = 1'b0;
        @(posedge vco_clk); #3;
        check(q == 1'b0, "R5 still held after one edge", q, 0);
        @(posedge vco_clk); #3;
        check(q == 1'b1, "R5 running after second edge", q, 1);
        check(qn == ~q, "R4 complement", qn, ~q);

        // R7: ratio changes take effect at the wrap
        change_case(3'b011, 3'b110, "R7 div4 to div8");
        change_case(3'b010, 3'b100, "R7 div3 to div5");

        mr = 1'b1;
        #50;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule